// File: doc/BRIEF.md
# Receive Cell Header Check and Filter

This block sits on the receive side of a cell-based line interface, after cell alignment has been found. It takes 53-byte cells one byte at a time, with a marker on the first byte of each cell. It checks the header check byte against the four header bytes and fixes any header that carries exactly one wrong bit. Three discard rules, each with its own enable, then remove unwanted cells before they reach the receive cell store. These rules catch uncorrectable headers, idle or unassigned cells, and headers that match a programmable pattern under a mask. The 48 payload bytes can optionally be descrambled with the self-synchronising x^43+1 scheme.

A surviving cell is handed on as one 32-bit header write, followed by 48 indexed payload byte writes. A discarded cell produces no write of any kind. Four saturating counters record how many cells were repaired and how many were dropped by each rule.

Top module: `rx_hec_filter`

## Requirements
- R1: The check byte is the CRC-8 of the four header bytes (generator x^8+x^2+x+1, register starting at zero, first byte and most significant bit first) XOR `coset_i`. A cell whose fifth byte equals this value is accepted unchanged. On the clock edge that samples byte 5, `hdr_we_o` rises with `hdr_o` holding bytes 1..4, byte 1 in bits 31:24.
- R2: A cell with exactly one wrong bit in the 40 header-plus-check bits is repaired. If the bad bit is in the header, `hdr_o` carries the corrected header. If it is in the check byte, the header is passed as received. `cnt_corr_o` counts every repaired cell.
- R3: With `hec_drop_en_i` high, a cell with any other nonzero mismatch gets no header write and no payload write, and `cnt_hec_o` increments.
- R4: With `hec_drop_en_i` low, an uncorrectable cell is written with its header as received, and no counter moves.
- R5: With `idle_drop_en_i` high, a cell whose header bits 31:1 are all zero is discarded and counted in `cnt_idle_o`. This covers idle 0x00000001 and unassigned 0x00000000. Any other header, or the same headers with the enable low, passes.
- R6: With `user_drop_en_i` high, a cell is discarded and counted in `cnt_user_o` when `((hdr ^ user_val_i) & user_mask_i) == 0`. Mask bits at zero are don't-care.
- R7: Discard priority is check-byte failure, then idle/unassigned, then user pattern. Exactly one drop counter moves per discarded cell. The idle and user rules test the corrected header.
- R8: With `descr_en_i` high, each payload bit is output as the received bit XOR the received payload bit 43 positions earlier, taken most significant bit first. The history runs over the payload bytes of every cell, kept or dropped, and starts at zero after reset. With the enable low, payload is passed as received.
- R9: Each payload byte of a kept cell is written one cycle after it is sampled, with `pay_idx_o` running 0..47. Bubbles in `byte_valid_i` only delay the writes.
- R10: All four counters saturate at all-ones.
- R11: After reset, the write strobes and all counters are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| byte_valid_i | input | 1 | Byte present this cycle |
| byte_sop_i | input | 1 | Byte is the first of a cell |
| byte_i | input | 8 | Received byte |
| descr_en_i | input | 1 | Payload descrambling on |
| hec_drop_en_i | input | 1 | Discard uncorrectable cells |
| idle_drop_en_i | input | 1 | Discard idle/unassigned cells |
| user_drop_en_i | input | 1 | Discard user-pattern matches |
| coset_i | input | 8 | Value XORed onto the check byte |
| user_val_i | input | 32 | User header pattern |
| user_mask_i | input | 32 | User compare mask |
| hdr_we_o | output | 1 | Header write strobe |
| hdr_o | output | 32 | Header to store (corrected) |
| pay_we_o | output | 1 | Payload byte write strobe |
| pay_idx_o | output | 6 | Payload byte index 0..47 |
| pay_o | output | 8 | Payload byte |
| cnt_corr_o | output | CNT_W | Repaired cells |
| cnt_hec_o | output | CNT_W | Cells dropped for check failure |
| cnt_idle_o | output | CNT_W | Idle/unassigned cells dropped |
| cnt_user_o | output | CNT_W | User-pattern cells dropped |

## Verification
The bench flips single bits in the header and in the check byte, and pairs of bits, with and without the check-byte discard enabled. A design with a wrong syndrome table would fail in one of two ways: it would miscorrect a header, or it would drop a repairable cell. It also sends idle cells that need repair first and errored cells that would otherwise match the idle rule. A design that filtered the raw header, or counted one cell twice, would show the wrong counter moving. The bench keeps the payload descrambler history running across dropped cells and with descrambling off. A design that paused the history would return garbled payload on the next kept cell. A long run of idle cells drives a narrow counter past all-ones, where a wrapping counter would read back a small value.

// File: rtl/rx_hec_pkg.sv
package rx_hec_pkg;
  localparam int CELL_BYTES = 53;
  localparam int HDR_BYTES  = 4;
  localparam int PAY_BYTES  = 48;
  localparam int CW_BITS    = 40;

  // CRC-8, generator x^8+x^2+x+1, msb first, zero start
  function automatic logic [7:0] crc8_hdr(input logic [31:0] h);
    logic [7:0] c;
    logic       fb;
    c = 8'h00;
    for (int i = 31; i >= 0; i--) begin
      fb = c[7] ^ h[i];
      c  = {c[6:0], 1'b0};
      if (fb) c = c ^ 8'h07;
    end
    return c;
  endfunction

  // syndrome produced by a single flipped bit at codeword position p
  function automatic logic [7:0] syn_of_pos(input int p);
    logic [39:0] e;
    e = 40'd1 << p;
    return crc8_hdr(e[39:8]) ^ e[7:0];
  endfunction
endpackage

// File: rtl/rx_hec_check.sv
module rx_hec_check
  import rx_hec_pkg::*;
(
  input  logic [31:0] hdr_i,
  input  logic [7:0]  hec_i,
  input  logic [7:0]  coset_i,
  output logic [31:0] hdr_o,
  output logic        corr_o,
  output logic        bad_o
);
  logic [7:0]         syn;
  logic [CW_BITS-1:0] hit;

  assign syn = crc8_hdr(hdr_i) ^ hec_i ^ coset_i;

  for (genvar p = 0; p < CW_BITS; p++) begin : g_pos
    localparam logic [7:0] SYN_P = syn_of_pos(p);
    assign hit[p] = (syn == SYN_P);
  end

  assign corr_o = |hit;
  assign bad_o  = (syn != 8'h00) && !corr_o;
  assign hdr_o  = hdr_i ^ hit[CW_BITS-1:8];
endmodule

// File: rtl/rx_cell_filter.sv
module rx_cell_filter (
  input  logic [31:0] hdr_i,
  input  logic        bad_i,
  input  logic        hec_en_i,
  input  logic        idle_en_i,
  input  logic        user_en_i,
  input  logic [31:0] user_val_i,
  input  logic [31:0] user_mask_i,
  output logic        drop_o,
  output logic        drop_hec_o,
  output logic        drop_idle_o,
  output logic        drop_user_o
);
  logic idle_m, user_m;

  assign idle_m = (hdr_i[31:1] == 31'd0);
  assign user_m = (((hdr_i ^ user_val_i) & user_mask_i) == 32'd0);

  assign drop_hec_o  = hec_en_i & bad_i;
  assign drop_idle_o = idle_en_i & idle_m & !drop_hec_o;
  assign drop_user_o = user_en_i & user_m & !drop_hec_o & !drop_idle_o;
  assign drop_o      = drop_hec_o | drop_idle_o | drop_user_o;
endmodule

// File: rtl/rx_descrambler.sv
module rx_descrambler #(
  parameter int TAP = 43
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       adv_i,
  input  logic       en_i,
  input  logic [7:0] byte_i,
  output logic [7:0] byte_o
);
  logic [TAP-1:0] sr_q, sr_d;
  logic [7:0]     plain;

  always_comb begin
    sr_d  = sr_q;
    plain = 8'h00;
    for (int i = 7; i >= 0; i--) begin
      plain[i] = byte_i[i] ^ sr_d[TAP-1];
      sr_d     = {sr_d[TAP-2:0], byte_i[i]};
    end
  end

  assign byte_o = en_i ? plain : byte_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    sr_q <= '0;
    else if (adv_i) sr_q <= sr_d;
  end
endmodule

// File: rtl/rx_sat_counters.sv
module rx_sat_counters #(
  parameter int N     = 4,
  parameter int CNT_W = 16
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [N-1:0]              inc_i,
  output logic [N-1:0][CNT_W-1:0]   cnt_o
);
  for (genvar g = 0; g < N; g++) begin : g_cnt
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                            cnt_o[g] <= '0;
      else if (inc_i[g] && (cnt_o[g] != '1)) cnt_o[g] <= cnt_o[g] + 1'b1;
    end
  end
endmodule

// File: rtl/rx_hec_filter.sv
module rx_hec_filter
  import rx_hec_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             byte_valid_i,
  input  logic             byte_sop_i,
  input  logic [7:0]       byte_i,
  input  logic             descr_en_i,
  input  logic             hec_drop_en_i,
  input  logic             idle_drop_en_i,
  input  logic             user_drop_en_i,
  input  logic [7:0]       coset_i,
  input  logic [31:0]      user_val_i,
  input  logic [31:0]      user_mask_i,
  output logic             hdr_we_o,
  output logic [31:0]      hdr_o,
  output logic             pay_we_o,
  output logic [5:0]       pay_idx_o,
  output logic [7:0]       pay_o,
  output logic [CNT_W-1:0] cnt_corr_o,
  output logic [CNT_W-1:0] cnt_hec_o,
  output logic [CNT_W-1:0] cnt_idle_o,
  output logic [CNT_W-1:0] cnt_user_o
);
  localparam int IDX_W = $clog2(CELL_BYTES + 1);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(CELL_BYTES - 1);
  localparam logic [IDX_W-1:0] HEC_IDX  = IDX_W'(HDR_BYTES);
  localparam int N_CNT = 4;

  logic [IDX_W-1:0] idx_q, cur_idx;
  logic             active_q, keep_q;
  logic [31:0]      hdr_sh_q;
  logic             take, is_hdr, is_hec, is_pay;

  logic [31:0] hdr_fix;
  logic        corr, bad;
  logic        drop, drop_hec, drop_idle, drop_user;
  logic [7:0]  pay_plain;
  logic [N_CNT-1:0]            cnt_inc;
  logic [N_CNT-1:0][CNT_W-1:0] cnt;

  assign take    = byte_valid_i && (byte_sop_i || active_q);
  assign cur_idx = byte_sop_i ? '0 : idx_q;
  assign is_hdr  = take && (cur_idx < HEC_IDX);
  assign is_hec  = take && (cur_idx == HEC_IDX);
  assign is_pay  = take && (cur_idx > HEC_IDX);

  rx_hec_check u_chk_hec (
    .hdr_i   (hdr_sh_q),
    .hec_i   (byte_i),
    .coset_i (coset_i),
    .hdr_o   (hdr_fix),
    .corr_o  (corr),
    .bad_o   (bad)
  );

  rx_cell_filter u_filt (
    .hdr_i       (hdr_fix),
    .bad_i       (bad),
    .hec_en_i    (hec_drop_en_i),
    .idle_en_i   (idle_drop_en_i),
    .user_en_i   (user_drop_en_i),
    .user_val_i  (user_val_i),
    .user_mask_i (user_mask_i),
    .drop_o      (drop),
    .drop_hec_o  (drop_hec),
    .drop_idle_o (drop_idle),
    .drop_user_o (drop_user)
  );

  rx_descrambler #(.TAP(43)) u_descr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .adv_i  (is_pay),
    .en_i   (descr_en_i),
    .byte_i (byte_i),
    .byte_o (pay_plain)
  );

  assign cnt_inc = {is_hec & drop_user, is_hec & drop_idle,
                    is_hec & drop_hec,  is_hec & corr};

  rx_sat_counters #(.N(N_CNT), .CNT_W(CNT_W)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .inc_i  (cnt_inc),
    .cnt_o  (cnt)
  );

  assign cnt_corr_o = cnt[0];
  assign cnt_hec_o  = cnt[1];
  assign cnt_idle_o = cnt[2];
  assign cnt_user_o = cnt[3];

  // cell position tracking
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q    <= '0;
      active_q <= 1'b0;
      hdr_sh_q <= '0;
      keep_q   <= 1'b0;
    end else if (take) begin
      idx_q    <= cur_idx + 1'b1;
      active_q <= (cur_idx != LAST_IDX);
      if (is_hdr)          hdr_sh_q <= {hdr_sh_q[23:0], byte_i};
      if (byte_sop_i)      keep_q   <= 1'b0;
      else if (is_hec)     keep_q   <= !drop;
    end
  end

  // buffer write side
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hdr_we_o  <= 1'b0;
      hdr_o     <= '0;
      pay_we_o  <= 1'b0;
      pay_idx_o <= '0;
      pay_o     <= '0;
    end else begin
      hdr_we_o <= is_hec && !drop;
      pay_we_o <= is_pay && keep_q;
      if (is_hec) hdr_o <= hdr_fix;
      if (is_pay) begin
        pay_idx_o <= 6'(cur_idx - HEC_IDX - 1'b1);
        pay_o     <= pay_plain;
      end
    end
  end
endmodule

// File: rtl/rx_hec_filter_chk.sv
module rx_hec_filter_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             hdr_we_o,
  input logic             pay_we_o,
  input logic [5:0]       pay_idx_o,
  input logic [CNT_W-1:0] cnt_corr_o,
  input logic [CNT_W-1:0] cnt_hec_o,
  input logic [CNT_W-1:0] cnt_idle_o,
  input logic [CNT_W-1:0] cnt_user_o
);
  logic       seen_hdr_q;
  logic [5:0] exp_idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seen_hdr_q <= 1'b0;
      exp_idx_q  <= '0;
    end else begin
      if (hdr_we_o) begin
        seen_hdr_q <= 1'b1;
        exp_idx_q  <= '0;
      end else if (pay_we_o) begin
        exp_idx_q <= exp_idx_q + 1'b1;
        if (pay_idx_o == 6'd47) seen_hdr_q <= 1'b0;
      end
    end
  end

  assert_pay_after_hdr_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pay_we_o |-> seen_hdr_q);

  assert_pay_idx_seq_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pay_we_o |-> (pay_idx_o == exp_idx_q));

  assert_cnt_step_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((cnt_corr_o == $past(cnt_corr_o)) || (cnt_corr_o == $past(cnt_corr_o) + 1)) &&
    ((cnt_hec_o  == $past(cnt_hec_o))  || (cnt_hec_o  == $past(cnt_hec_o)  + 1)) &&
    ((cnt_idle_o == $past(cnt_idle_o)) || (cnt_idle_o == $past(cnt_idle_o) + 1)) &&
    ((cnt_user_o == $past(cnt_user_o)) || (cnt_user_o == $past(cnt_user_o) + 1)));

  assert_one_drop_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones({cnt_hec_o != $past(cnt_hec_o), cnt_idle_o != $past(cnt_idle_o),
                cnt_user_o != $past(cnt_user_o)}) <= 1);

  assert_hec_drop_no_hdr_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_hec_o != $past(cnt_hec_o)) |-> !hdr_we_o);

  assert_idle_drop_no_hdr_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_idle_o != $past(cnt_idle_o)) |-> !hdr_we_o);

  assert_user_drop_no_hdr_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_user_o != $past(cnt_user_o)) |-> !hdr_we_o);
endmodule

bind rx_hec_filter rx_hec_filter_chk #(.CNT_W(CNT_W)) u_rx_hec_filter_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .hdr_we_o   (hdr_we_o),
  .pay_we_o   (pay_we_o),
  .pay_idx_o  (pay_idx_o),
  .cnt_corr_o (cnt_corr_o),
  .cnt_hec_o  (cnt_hec_o),
  .cnt_idle_o (cnt_idle_o),
  .cnt_user_o (cnt_user_o)
);

// File: tb/tb_rx_hec_filter.sv
module tb_rx_hec_filter;
  localparam int CW = 4;
  localparam int SAT = (1 << CW) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic byte_valid = 1'b0, byte_sop = 1'b0;
  logic [7:0] byte_d = 8'h00;
  logic descr_en = 1'b1, hec_en = 1'b1, idle_en = 1'b0, user_en = 1'b0;
  logic [7:0] coset = 8'h55;
  logic [31:0] user_val = 32'h0, user_mask = 32'h0;
  logic hdr_we, pay_we;
  logic [31:0] hdr_q;
  logic [5:0] pay_idx;
  logic [7:0] pay_q;
  logic [CW-1:0] c_corr, c_hec, c_idle, c_user;

  always #2 clk = ~clk;

  rx_hec_filter #(.CNT_W(CW)) dut (
    .clk_i(clk), .rst_ni(rst_n), .byte_valid_i(byte_valid), .byte_sop_i(byte_sop),
    .byte_i(byte_d), .descr_en_i(descr_en), .hec_drop_en_i(hec_en),
    .idle_drop_en_i(idle_en), .user_drop_en_i(user_en), .coset_i(coset),
    .user_val_i(user_val), .user_mask_i(user_mask), .hdr_we_o(hdr_we), .hdr_o(hdr_q),
    .pay_we_o(pay_we), .pay_idx_o(pay_idx), .pay_o(pay_q), .cnt_corr_o(c_corr),
    .cnt_hec_o(c_hec), .cnt_idle_o(c_idle), .cnt_user_o(c_user)
  );

  int checks = 0, errors = 0;
  int hdr_n = 0, pay_n = 0;
  bit idx_bad = 1'b0;
  logic [31:0] last_hdr;
  logic [7:0] pay_cap [48];
  logic [7:0] exp_plain [48];
  logic [7:0] exp_line [48];
  logic [42:0] scr_st = '0;
  int e_corr = 0, e_hec = 0, e_idle = 0, e_user = 0;

  always @(negedge clk) if (rst_n) begin
    if (hdr_we) begin hdr_n++; last_hdr = hdr_q; end
    if (pay_we) begin
      if (int'(pay_idx) != pay_n) idx_bad = 1'b1;
      pay_cap[pay_idx] = pay_q;
      pay_n++;
    end
  end

  function automatic logic [7:0] crc8(input logic [31:0] h);
    logic [7:0] c = 8'h00;
    for (int i = 31; i >= 0; i--) begin
      logic fb = c[7] ^ h[i];
      c = {c[6:0], 1'b0} ^ (fb ? 8'h07 : 8'h00);
    end
    return c;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int sat(input int v);
    return (v > SAT) ? SAT : v;
  endfunction

  task automatic check_cnt(input string req);
    chk(int'(c_corr) == sat(e_corr), {req, " corr count"}, 32'(c_corr), 32'(sat(e_corr)));
    chk(int'(c_hec)  == sat(e_hec),  {req, " hec count"},  32'(c_hec),  32'(sat(e_hec)));
    chk(int'(c_idle) == sat(e_idle), {req, " idle count"}, 32'(c_idle), 32'(sat(e_idle)));
    chk(int'(c_user) == sat(e_user), {req, " user count"}, 32'(c_user), 32'(sat(e_user)));
  endtask

  // send one cell; flip = {header bits, check bits} error pattern
  task automatic run_cell(input logic [31:0] hdr, input logic [39:0] flip, input bit gap,
                          input bit keep, input logic [31:0] exp_hdr, input string req);
    logic [7:0] line [53];
    logic [31:0] h_tx;
    h_tx = hdr ^ flip[39:8];
    for (int i = 0; i < 4; i++) line[i] = h_tx[31-8*i -: 8];
    line[4] = crc8(hdr) ^ coset ^ flip[7:0];
    for (int i = 0; i < 48; i++) begin
      logic [7:0] p, s;
      p = 8'(hdr[7:0] + 8'(i * 37) + 8'h1d);
      for (int b = 7; b >= 0; b--) begin
        s[b] = p[b] ^ scr_st[42];
        scr_st = {scr_st[41:0], s[b]};
      end
      exp_plain[i] = p;
      exp_line[i]  = s;
      line[5+i]    = s;
    end
    hdr_n = 0; pay_n = 0; idx_bad = 1'b0;
    for (int i = 0; i < 53; i++) begin
      @(negedge clk);
      byte_valid = 1'b1; byte_sop = (i == 0); byte_d = line[i];
      if (gap && (i % 3 == 2)) begin
        @(negedge clk);
        byte_valid = 1'b0; byte_sop = 1'b0;
      end
    end
    @(negedge clk);
    byte_valid = 1'b0; byte_sop = 1'b0;
    repeat (3) @(negedge clk);
    if (keep) begin
      bit pay_ok = 1'b1;
      chk(hdr_n == 1, {req, " header write"}, 32'(hdr_n), 32'd1);
      chk(last_hdr == exp_hdr, {req, " header value"}, last_hdr, exp_hdr);
      chk(pay_n == 48 && !idx_bad, {req, " payload writes"}, 32'(pay_n), 32'd48);
      for (int i = 0; i < 48; i++)
        if (pay_cap[i] != (descr_en ? exp_plain[i] : exp_line[i])) pay_ok = 1'b0;
      chk(pay_ok, {req, " payload bytes"}, 32'(pay_ok), 32'd1);
    end else begin
      chk(hdr_n == 0 && pay_n == 0, {req, " no writes on drop"}, 32'(hdr_n + pay_n), 32'd0);
    end
    check_cnt(req);
  endtask

  task automatic t_reset();
    chk(!hdr_we && !pay_we, "R11 strobes after reset", {30'd0, hdr_we, pay_we}, 32'd0);
    check_cnt("R11");
  endtask

  task automatic t_clean();
    run_cell(32'h1234_5670, 40'd0, 1'b0, 1'b1, 32'h1234_5670, "R1");
    run_cell(32'h0A0B_0C02, 40'd0, 1'b1, 1'b1, 32'h0A0B_0C02, "R9 gaps");
    coset = 8'h00;
    run_cell(32'h7654_3218, 40'd0, 1'b0, 1'b1, 32'h7654_3218, "R1 zero coset");
    coset = 8'h55;
  endtask

  task automatic t_single();
    e_corr++;
    run_cell(32'h1234_5670, 40'd1 << 37, 1'b0, 1'b1, 32'h1234_5670, "R2 header bit");
    e_corr++;
    run_cell(32'h2468_ACE0, 40'd1 << 2, 1'b0, 1'b1, 32'h2468_ACE0, "R2 check bit");
    e_corr++;
    run_cell(32'h1357_9BD0, 40'd1 << 8, 1'b0, 1'b1, 32'h1357_9BD0, "R2 lsb header bit");
  endtask

  task automatic t_double();
    hec_en = 1'b1; e_hec++;
    run_cell(32'h1111_2220, (40'd1 << 20) | (40'd1 << 3), 1'b0, 1'b0, 32'h0, "R3");
    hec_en = 1'b0;
    run_cell(32'h1111_2220, (40'd1 << 20) | (40'd1 << 30), 1'b0, 1'b1,
             32'h1111_2220 ^ 32'h0040_1000, "R4");
    hec_en = 1'b1;
  endtask

  task automatic t_idle();
    idle_en = 1'b1; e_idle++;
    run_cell(32'h0000_0001, 40'd0, 1'b0, 1'b0, 32'h0, "R5 idle");
    e_idle++;
    run_cell(32'h0000_0000, 40'd0, 1'b0, 1'b0, 32'h0, "R5 unassigned");
    run_cell(32'h0000_0010, 40'd0, 1'b0, 1'b1, 32'h0000_0010, "R5 non-idle");
    idle_en = 1'b0;
    run_cell(32'h0000_0001, 40'd0, 1'b0, 1'b1, 32'h0000_0001, "R5 disabled");
  endtask

  task automatic t_user();
    user_en = 1'b1; user_val = 32'h0ABC_0000; user_mask = 32'hFFFF_0000; e_user++;
    run_cell(32'h0ABC_1230, 40'd0, 1'b0, 1'b0, 32'h0, "R6 match");
    run_cell(32'h0ABD_1230, 40'd0, 1'b0, 1'b1, 32'h0ABD_1230, "R6 miss");
    user_en = 1'b0;
  endtask

  task automatic t_prio();
    idle_en = 1'b1; user_en = 1'b1; user_mask = 32'h0; e_idle++;
    run_cell(32'h0000_0001, 40'd0, 1'b0, 1'b0, 32'h0, "R7 idle over user");
    e_hec++;
    run_cell(32'h0000_0001, (40'd1 << 9) | (40'd1 << 0), 1'b0, 1'b0, 32'h0, "R7 hec over idle");
    e_corr++; e_idle++;
    run_cell(32'h0000_0001, 40'd1 << 33, 1'b0, 1'b0, 32'h0, "R7 corrected then idle");
    user_en = 1'b0; idle_en = 1'b0;
  endtask

  task automatic t_descr();
    descr_en = 1'b0;
    run_cell(32'h5555_AAA0, 40'd0, 1'b0, 1'b1, 32'h5555_AAA0, "R8 descramble off");
    descr_en = 1'b1;
    run_cell(32'h3C3C_3C30, 40'd0, 1'b0, 1'b1, 32'h3C3C_3C30, "R8 history across cells");
  endtask

  task automatic t_sat();
    idle_en = 1'b1;
    for (int k = 0; k < 18; k++) begin
      e_idle++;
      run_cell(32'h0000_0000, 40'd0, 1'b0, 1'b0, 32'h0, "R10 saturate");
    end
    chk(int'(c_idle) == SAT, "R10 idle counter held at max", 32'(c_idle), 32'(SAT));
    idle_en = 1'b0;
    run_cell(32'h0102_0300, 40'd0, 1'b0, 1'b1, 32'h0102_0300, "R8 after long drop run");
  endtask

  initial begin
    #(4 * 150000);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_clean();
    t_single();
    t_double();
    t_idle();
    t_user();
    t_prio();
    t_descr();
    t_sat();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule